// File: doc/BRIEF.md
# Ladder Bit-Instruction Evaluator

This block runs single relay-ladder instructions against a small on-chip bit memory, one scan step at a time. Each accepted step brings an opcode, a bit address, an edge-history instance number and the incoming rung state. Contact opcodes return an outgoing rung state derived from the addressed bit or from the rung's own history. Coil opcodes write the addressed bit and pass the rung through unchanged, so several outputs can hang off one rung. The outgoing rung is registered and is read one cycle after the step.

Every memory bit has a retention class, taken from the kind of coil that last wrote it. A restart input models a controller power cycle. It clears every bit whose last writer was a non-retentive coil, keeps the bits last written by a retentive coil, and wipes the edge-history registers used by the one-scan transition contacts and the transition-sensing coils.

The controller has two states. `ST_RUN` accepts steps. `ST_HOLDOFF` lasts one cycle after a restart and ignores steps. The transitions are: `ST_RUN -> ST_HOLDOFF` when restart is high, `ST_HOLDOFF -> ST_HOLDOFF` while restart stays high, and `ST_HOLDOFF -> ST_RUN` once restart is low.

Top module: `ladder_bit_engine`

## Requirements
- R1: After hard reset (`rst_n` low), `rung_out` is 0, every memory bit reads 0 and every edge history is 0.
- R2: Opcode 0 (make contact) gives `rung_out = rung_in AND bit`. Opcode 1 (break contact) gives `rung_out = rung_in AND NOT bit`.
- R3: Opcode 2 (rising contact) gives 1 only when `rung_in` is 1 and the history of the selected instance is 0. It then stores `rung_in` in that history, so the output lasts one scan.
- R4: Opcode 3 (falling contact) gives 1 only when `rung_in` is 0 and the history of the selected instance is 1. It then stores `rung_in` in that history.
- R5: Opcode 4 (plain coil) writes `rung_in` into the bit. Opcode 5 (inverting coil) writes `NOT rung_in`. Both are non-retentive.
- R6: Opcode 6 (latch) writes 1 and opcode 7 (unlatch) writes 0, but only when `rung_in` is 1. When the rung is 0 the bit keeps its value. Both are non-retentive.
- R7: Opcode 11 (rise-sensing coil) sets the bit when the instance history is 0 and `rung_in` is 1, and otherwise leaves the bit alone. Opcode 12 (fall-sensing coil) clears the bit when the history is 1 and `rung_in` is 0, and otherwise leaves the bit alone. Both store `rung_in` in the history, and a bit they write becomes non-retentive.
- R8: Opcodes 8, 9 and 10 are the retentive plain coil, latch and unlatch. A power cycle clears every bit whose last writer was non-retentive and keeps every bit whose last writer was retentive.
- R9: Each instance number has its own history register. A power cycle clears all of these registers.
- R10: A step presented in the same cycle as `power_cycle`, or in the cycle right after it, is dropped: it writes nothing and no history changes. `rung_out` reads 0 after a power cycle.
- R11: Every coil opcode drives `rung_out` with `rung_in`. The result of a step appears on `rung_out` at the clock edge that accepts the step and holds until the next accepted step.
- R12: Opcodes 13 to 15 do nothing except pass `rung_in` to `rung_out`. They write no bit and no history.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hard reset, clears everything |
| step | input | 1 | Strobe: evaluate the presented instruction this cycle |
| opcode | input | 4 | Instruction code (see requirements) |
| bit_addr | input | 5 | Address of the memory bit |
| inst_sel | input | 3 | Edge-history instance number |
| rung_in | input | 1 | Incoming rung state |
| power_cycle | input | 1 | Models a controller restart |
| rung_out | output | 1 | Registered outgoing rung state |

## Verification
A step and a restart can land in the same cycle, and a step can also land in the holdoff cycle that follows a restart. The bench provokes both. It drives a retentive unlatch on a retained bit together with the restart pulse, then drives a retentive latch during the holdoff cycle. It then reads both bits back with make contacts: the retained bit must still be 1, the bit written during holdoff must still be 0, and `rung_out` must be 0 in the cycle after.

// File: rtl/ladder_pkg.sv
package ladder_pkg;

    typedef enum logic [3:0] {
        OP_MAKE      = 4'd0,
        OP_BREAK     = 4'd1,
        OP_RISE_CT   = 4'd2,
        OP_FALL_CT   = 4'd3,
        OP_COIL      = 4'd4,
        OP_COIL_INV  = 4'd5,
        OP_LATCH     = 4'd6,
        OP_UNLATCH   = 4'd7,
        OP_COIL_R    = 4'd8,
        OP_LATCH_R   = 4'd9,
        OP_UNLATCH_R = 4'd10,
        OP_RISE_COIL = 4'd11,
        OP_FALL_COIL = 4'd12
    } ladder_op_e;

    typedef enum logic [0:0] {
        ST_RUN     = 1'b0,
        ST_HOLDOFF = 1'b1
    } ctrl_state_e;

endpackage

// File: rtl/ladder_step_ctrl.sv
module ladder_step_ctrl
    import ladder_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic power_cycle,
    output logic accept,
    output logic wipe
);

    ctrl_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:     if (power_cycle) state_d = ST_HOLDOFF;
            ST_HOLDOFF: if (!power_cycle) state_d = ST_RUN;
            default:    state_d = ST_RUN;
        endcase
    end

    always_comb begin
        wipe   = power_cycle;
        accept = 1'b0;
        unique case (state_q)
            ST_RUN:     accept = step && !power_cycle;
            ST_HOLDOFF: accept = 1'b0;
            default:    accept = 1'b0;
        endcase
    end

    // R10: no step is taken during the holdoff state
    a_r10_holdoff_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLDOFF) |-> !accept);

    // R10: a restart always leads into holdoff
    a_r10_enter_holdoff: assert property (@(posedge clk) disable iff (!rst_n)
        power_cycle |=> (state_q == ST_HOLDOFF));

endmodule

// File: rtl/ladder_edge_bank.sv
module ladder_edge_bank #(
    parameter int NINST = 8,
    localparam int IW = (NINST > 1) ? $clog2(NINST) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wipe,
    input  logic          upd,
    input  logic [IW-1:0] idx,
    input  logic          level,
    output logic          prev_o
);

    logic [NINST-1:0] hist_q;

    for (genvar g = 0; g < NINST; g++) begin : g_hist
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                hist_q[g] <= 1'b0;
            end else if (wipe) begin
                hist_q[g] <= 1'b0;
            end else if (upd && (idx == IW'(g))) begin
                hist_q[g] <= level;
            end
        end
    end

    assign prev_o = hist_q[idx];

    // R9: restart empties every history register
    a_r9_hist_wiped: assert property (@(posedge clk) disable iff (!rst_n)
        wipe |=> (hist_q == '0));

    // R3: an update stores the rung level in the chosen instance
    a_r3_hist_store: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !wipe) |=> (hist_q[$past(idx)] == $past(level)));

    // R9: instances not selected keep their history
    a_r9_hist_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd && !wipe) |=> $stable(hist_q));

endmodule

// File: rtl/ladder_bit_store.sv
module ladder_bit_store #(
    parameter int NBITS = 32,
    localparam int AW = (NBITS > 1) ? $clog2(NBITS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wipe,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic          wdata,
    input  logic          wret,
    input  logic [AW-1:0] raddr,
    output logic          rdata
);

    logic [NBITS-1:0] mem_q;
    logic [NBITS-1:0] keep_q;

    for (genvar g = 0; g < NBITS; g++) begin : g_cell
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem_q[g]  <= 1'b0;
                keep_q[g] <= 1'b0;
            end else if (wipe) begin
                mem_q[g]  <= mem_q[g] & keep_q[g];
            end else if (we && (waddr == AW'(g))) begin
                mem_q[g]  <= wdata;
                keep_q[g] <= wret;
            end
        end
    end

    assign rdata = mem_q[raddr];

    // R8: after restart no non-retained bit is set
    a_r8_volatile_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        wipe |=> ((mem_q & ~keep_q) == '0));

    // R8: retained bits survive a restart
    a_r8_retained_kept: assert property (@(posedge clk) disable iff (!rst_n)
        wipe |=> ((mem_q & keep_q) == ($past(mem_q) & $past(keep_q))));

    // R5: an accepted write lands at its address
    a_r5_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !wipe) |=> (mem_q[$past(waddr)] == $past(wdata)));

    // R12: without write or restart the memory is unchanged
    a_r12_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!we && !wipe) |=> $stable(mem_q));

endmodule

// File: rtl/ladder_bit_engine.sv
module ladder_bit_engine
    import ladder_pkg::*;
#(
    parameter int NBITS = 32,
    parameter int NINST = 8,
    localparam int AW = (NBITS > 1) ? $clog2(NBITS) : 1,
    localparam int IW = (NINST > 1) ? $clog2(NINST) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic [3:0]    opcode,
    input  logic [AW-1:0] bit_addr,
    input  logic [IW-1:0] inst_sel,
    input  logic          rung_in,
    input  logic          power_cycle,
    output logic          rung_out
);

    logic accept, wipe;
    logic bit_rd, hist_prev;
    logic wr_en, wr_data, wr_keep, hist_upd;
    logic rung_d;

    ladder_step_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .step        (step),
        .power_cycle (power_cycle),
        .accept      (accept),
        .wipe        (wipe)
    );

    ladder_edge_bank #(.NINST(NINST)) u_edges (
        .clk    (clk),
        .rst_n  (rst_n),
        .wipe   (wipe),
        .upd    (hist_upd),
        .idx    (inst_sel),
        .level  (rung_in),
        .prev_o (hist_prev)
    );

    ladder_bit_store #(.NBITS(NBITS)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .wipe  (wipe),
        .we    (wr_en),
        .waddr (bit_addr),
        .wdata (wr_data),
        .wret  (wr_keep),
        .raddr (bit_addr),
        .rdata (bit_rd)
    );

    // instruction decode: next rung and write request
    always_comb begin
        rung_d   = rung_in;
        wr_en    = 1'b0;
        wr_data  = 1'b0;
        wr_keep  = 1'b0;
        hist_upd = 1'b0;
        case (opcode)
            OP_MAKE:    rung_d = rung_in & bit_rd;
            OP_BREAK:   rung_d = rung_in & ~bit_rd;
            OP_RISE_CT: begin
                rung_d   = rung_in & ~hist_prev;
                hist_upd = accept;
            end
            OP_FALL_CT: begin
                rung_d   = ~rung_in & hist_prev;
                hist_upd = accept;
            end
            OP_COIL: begin
                wr_en   = accept;
                wr_data = rung_in;
            end
            OP_COIL_INV: begin
                wr_en   = accept;
                wr_data = ~rung_in;
            end
            OP_LATCH: begin
                wr_en   = accept && rung_in;
                wr_data = 1'b1;
            end
            OP_UNLATCH: begin
                wr_en   = accept && rung_in;
                wr_data = 1'b0;
            end
            OP_COIL_R: begin
                wr_en   = accept;
                wr_data = rung_in;
                wr_keep = 1'b1;
            end
            OP_LATCH_R: begin
                wr_en   = accept && rung_in;
                wr_data = 1'b1;
                wr_keep = 1'b1;
            end
            OP_UNLATCH_R: begin
                wr_en   = accept && rung_in;
                wr_data = 1'b0;
                wr_keep = 1'b1;
            end
            OP_RISE_COIL: begin
                hist_upd = accept;
                wr_en    = accept && rung_in && !hist_prev;
                wr_data  = 1'b1;
            end
            OP_FALL_COIL: begin
                hist_upd = accept;
                wr_en    = accept && !rung_in && hist_prev;
                wr_data  = 1'b0;
            end
            default: rung_d = rung_in;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rung_out <= 1'b0;
        end else if (wipe) begin
            rung_out <= 1'b0;
        end else if (accept) begin
            rung_out <= rung_d;
        end
    end

    // R10: rung output is cleared by a restart
    a_r10_rung_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        wipe |=> !rung_out);

    // R11: rung output only moves on an accepted step
    a_r11_rung_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!accept && !wipe) |=> $stable(rung_out));

    // R10: nothing is written while a restart is present
    a_r10_no_write_on_wipe: assert property (@(posedge clk) disable iff (!rst_n)
        wipe |-> (!wr_en && !hist_upd));

endmodule

// File: tb/ladder_bit_engine_test.sv
module ladder_bit_engine_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       step = 1'b0;
    logic [3:0] opcode = 4'd0;
    logic [4:0] bit_addr = 5'd0;
    logic [2:0] inst_sel = 3'd0;
    logic       rung_in = 1'b0;
    logic       power_cycle = 1'b0;
    logic       rung_out;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ladder_bit_engine uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .step        (step),
        .opcode      (opcode),
        .bit_addr    (bit_addr),
        .inst_sel    (inst_sel),
        .rung_in     (rung_in),
        .power_cycle (power_cycle),
        .rung_out    (rung_out)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0b expected %0b", tag, act, exp);
        end
    endtask

    // one accepted step; result is sampled at the following falling edge
    task automatic run_step(input logic [3:0] op, input logic [4:0] a,
                            input logic [2:0] inst, input logic r);
        @(negedge clk);
        opcode = op; bit_addr = a; inst_sel = inst; rung_in = r; step = 1'b1;
        @(negedge clk);
        step = 1'b0;
    endtask

    task automatic read_bit(input string tag, input logic [4:0] a, input logic exp);
        run_step(4'd0, a, 3'd0, 1'b1);
        check(tag, rung_out, exp);
    endtask

    task automatic restart();
        @(negedge clk);
        power_cycle = 1'b1;
        @(negedge clk);
        power_cycle = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 rung_out after reset", rung_out, 1'b0);
        read_bit("R1 bit 3 after reset", 5'd3, 1'b0);
        read_bit("R1 bit 31 after reset", 5'd31, 1'b0);
    endtask

    task automatic t_contacts();
        run_step(4'd6, 5'd3, 3'd0, 1'b1);
        run_step(4'd0, 5'd3, 3'd0, 1'b1); check("R2 make on set bit", rung_out, 1'b1);
        run_step(4'd0, 5'd3, 3'd0, 1'b0); check("R2 make with false rung", rung_out, 1'b0);
        run_step(4'd1, 5'd3, 3'd0, 1'b1); check("R2 break on set bit", rung_out, 1'b0);
        run_step(4'd1, 5'd4, 3'd0, 1'b1); check("R2 break on clear bit", rung_out, 1'b1);
    endtask

    task automatic t_coils();
        run_step(4'd4, 5'd10, 3'd0, 1'b1); check("R11 coil passes rung", rung_out, 1'b1);
        read_bit("R5 plain coil wrote 1", 5'd10, 1'b1);
        run_step(4'd5, 5'd10, 3'd0, 1'b1); check("R11 inv coil passes rung", rung_out, 1'b1);
        read_bit("R5 inverting coil true rung", 5'd10, 1'b0);
        run_step(4'd5, 5'd10, 3'd0, 1'b0); check("R11 coil passes false rung", rung_out, 1'b0);
        read_bit("R5 inverting coil false rung", 5'd10, 1'b1);
    endtask

    task automatic t_latch();
        run_step(4'd6, 5'd11, 3'd0, 1'b1); read_bit("R6 latch sets", 5'd11, 1'b1);
        run_step(4'd6, 5'd11, 3'd0, 1'b0); read_bit("R6 latch false holds", 5'd11, 1'b1);
        run_step(4'd7, 5'd11, 3'd0, 1'b0); read_bit("R6 unlatch false holds", 5'd11, 1'b1);
        run_step(4'd7, 5'd11, 3'd0, 1'b1); read_bit("R6 unlatch clears", 5'd11, 1'b0);
    endtask

    task automatic t_edges();
        run_step(4'd2, 5'd0, 3'd2, 1'b0); check("R3 rise low", rung_out, 1'b0);
        run_step(4'd2, 5'd0, 3'd2, 1'b1); check("R3 rise edge", rung_out, 1'b1);
        run_step(4'd2, 5'd0, 3'd2, 1'b1); check("R3 rise only one scan", rung_out, 1'b0);
        run_step(4'd2, 5'd0, 3'd5, 1'b1); check("R9 separate instance", rung_out, 1'b1);
        run_step(4'd3, 5'd0, 3'd3, 1'b1); check("R4 fall while high", rung_out, 1'b0);
        run_step(4'd3, 5'd0, 3'd3, 1'b0); check("R4 fall edge", rung_out, 1'b1);
        run_step(4'd3, 5'd0, 3'd3, 1'b0); check("R4 fall only one scan", rung_out, 1'b0);
    endtask

    task automatic t_sense_coils();
        run_step(4'd11, 5'd12, 3'd4, 1'b0); read_bit("R7 rise coil no edge", 5'd12, 1'b0);
        run_step(4'd11, 5'd12, 3'd4, 1'b1); read_bit("R7 rise coil sets", 5'd12, 1'b1);
        run_step(4'd11, 5'd12, 3'd4, 1'b0); read_bit("R7 rise coil holds", 5'd12, 1'b1);
        run_step(4'd12, 5'd12, 3'd6, 1'b1); read_bit("R7 fall coil no edge", 5'd12, 1'b1);
        run_step(4'd12, 5'd12, 3'd6, 1'b0); read_bit("R7 fall coil clears", 5'd12, 1'b0);
        run_step(4'd12, 5'd12, 3'd6, 1'b1); read_bit("R7 fall coil holds", 5'd12, 1'b0);
    endtask

    task automatic t_unused();
        run_step(4'd15, 5'd13, 3'd1, 1'b1); check("R12 unused passes rung", rung_out, 1'b1);
        read_bit("R12 unused wrote nothing", 5'd13, 1'b0);
    endtask

    task automatic t_retention();
        run_step(4'd8, 5'd20, 3'd0, 1'b1);
        run_step(4'd9, 5'd21, 3'd0, 1'b1);
        run_step(4'd9, 5'd22, 3'd0, 1'b1);
        run_step(4'd4, 5'd22, 3'd0, 1'b1);
        run_step(4'd2, 5'd0, 3'd2, 1'b1);
        restart();
        check("R10 rung_out after restart", rung_out, 1'b0);
        read_bit("R8 retentive coil kept", 5'd20, 1'b1);
        read_bit("R8 retentive latch kept", 5'd21, 1'b1);
        read_bit("R8 volatile bit cleared", 5'd3, 1'b0);
        read_bit("R8 reclassified bit cleared", 5'd22, 1'b0);
        run_step(4'd3, 5'd0, 3'd2, 1'b0); check("R9 history wiped", rung_out, 1'b0);
    endtask

    task automatic t_collision();
        run_step(4'd0, 5'd20, 3'd0, 1'b1);
        @(negedge clk);
        opcode = 4'd10; bit_addr = 5'd20; rung_in = 1'b1; step = 1'b1; power_cycle = 1'b1;
        @(negedge clk);
        power_cycle = 1'b0;
        opcode = 4'd9; bit_addr = 5'd25; rung_in = 1'b1; step = 1'b1;
        @(negedge clk);
        step = 1'b0;
        check("R10 rung_out after collision", rung_out, 1'b0);
        read_bit("R10 step with restart dropped", 5'd20, 1'b1);
        read_bit("R10 step in holdoff dropped", 5'd25, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_contacts();
        t_coils();
        t_latch();
        t_edges();
        t_sense_coils();
        t_unused();
        t_retention();
        t_collision();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule